// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog that counts a free-running clock and asks for a chip reset when software stops servicing it. A prescaler of up to seven bits sits in front of the watchdog counter. A single assignment bit gives the prescaler either to the watchdog or to a general-purpose timer elsewhere in the chip. While the timer owns the prescaler, the watchdog counts every clock, and the prescaler keeps its value here.

Software services the watchdog with a one-cycle clear command. The command zeroes the watchdog count. It zeroes the prescaler only when the watchdog owns the prescaler. It also sets both status flags, time-out and power-down. When the count wraps, the block pulses a reset request and drops the time-out flag. The flag stays low until the next clear or reset. All pins are plain control and status signals, so there is no streaming interface and no back-pressure.

Top module: `wdog_shared_pre`

## Requirements
- R1: After reset, `to_flag` and `pd_flag` are 1, `rst_req` is 0, and the count and prescaler are both zero. With the watchdog owning the prescaler at select `s`, the first request therefore follows 2^(CNT_W+s) clock edges after reset release.
- R2: A clear command zeroes the count, so the next request comes exactly 2^(CNT_W+s) edges after the clear edge when `pre_to_wdt`=1. This holds even when the clear arrives partway through a period.
- R3: The clock edge that samples `clr_wdt`=1 sets both `to_flag` and `pd_flag` to 1.
- R4: An overflow drives `rst_req` high for exactly one cycle and clears `to_flag` to 0. The flag then holds 0 until a clear or reset.
- R5: With `pre_to_wdt`=0 the watchdog advances on every clock, whatever `pre_sel` holds, so a request follows 2^CNT_W edges after a clear.
- R6: With `pre_to_wdt`=1 the watchdog advances once every 2^`pre_sel` clocks. `pre_sel` is 3 bits, so 0 gives 1:1 and 7 gives 1:128.
- R7: With `pre_to_wdt`=0 the prescaler holds its value, and a clear leaves it untouched. If the prescaler held p when ownership left, select s and the watchdog is then cleared without the prescaler, the first tick after ownership returns comes 2^s−p clocks later.
- R8: A clear on the same edge as an overflow wins: no request is issued and `to_flag` stays 1.
- R9: `pd_flag` does not change on an overflow. Only reset or a clear sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that the watchdog counts |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_wdt | input | 1 | One-cycle clear-watchdog command from the core |
| pre_to_wdt | input | 1 | Prescaler owner: 1 = watchdog, 0 = general timer |
| pre_sel | input | SEL_W (3) | Prescale ratio exponent, ratio 2^pre_sel |
| rst_req | output | 1 | One-cycle reset request on overflow |
| to_flag | output | 1 | Time-out status flag, 0 after an overflow |
| pd_flag | output | 1 | Power-down status flag |

## Verification
The bench builds the block with CNT_W=4 and the default SEL_W=3. A full period then lasts 16 clocks at 1:1 and 2048 clocks at 1:128. This short count lets the bench reach every prescale ratio, repeated overflows, a clear landing on the overflow edge, and ownership handover with a partly filled prescaler, all well inside the run time. Random clears, ownership flips and select changes are then compared each cycle against a reference model built from the requirements.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    OWN_TIMER = 1'b0,
    OWN_WDOG  = 1'b1
  } pre_owner_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_wdt,
  input  logic             pre_to_wdt,
  input  logic [SEL_W-1:0] pre_sel,
  output logic             wdt_tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] one_w;
  logic [PRE_W-1:0] sel_mask;
  pre_owner_e       owner;

  assign owner    = pre_owner_e'(pre_to_wdt);
  assign one_w    = PRE_W'(1);
  assign sel_mask = (one_w << pre_sel) - one_w;

  always_comb begin
    if (owner == OWN_WDOG) wdt_tick = ((pre_q & sel_mask) == sel_mask);
    else                   wdt_tick = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (owner == OWN_WDOG) begin
      if (clr_wdt) pre_q <= '0;
      else         pre_q <= pre_q + one_w;
    end
  end

  // R7: prescaler holds while the timer owns it
  a_r7_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_to_wdt |=> $stable(pre_q));
  // R2: clear with watchdog ownership zeroes the prescaler
  a_r2_pre_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wdt && pre_to_wdt) |=> (pre_q == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_wdt,
  input  logic pre_to_wdt,
  input  logic wdt_tick,
  output logic ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign ovf = wdt_tick && (cnt_q == CNT_MAX) && !clr_wdt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr_wdt)  cnt_q <= '0;
    else if (wdt_tick) cnt_q <= cnt_q + CNT_W'(1);
  end

  // R5: without the prescaler every clock is a tick
  a_r5_tick_every: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_to_wdt |-> wdt_tick);
  // R2: clear zeroes the count
  a_r2_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wdt |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_wdt,
  input  logic ovf,
  output logic rst_req,
  output logic to_flag,
  output logic pd_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      to_flag <= 1'b1;
      pd_flag <= 1'b1;
    end else begin
      rst_req <= ovf;
      if (clr_wdt) begin
        to_flag <= 1'b1;
        pd_flag <= 1'b1;
      end else if (ovf) begin
        to_flag <= 1'b0;
      end
    end
  end

  a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r4_to_low: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !to_flag);
  a_r3_clr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wdt |=> (to_flag && pd_flag));
  a_r8_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wdt |=> !rst_req);
  a_r9_pd_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(pd_flag));
endmodule

// File: rtl/wdog_shared_pre.sv
module wdog_shared_pre #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_wdt,
  input  logic             pre_to_wdt,
  input  logic [SEL_W-1:0] pre_sel,
  output logic             rst_req,
  output logic             to_flag,
  output logic             pd_flag
);
  logic wdt_tick;
  logic ovf;

  wdog_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_wdt(clr_wdt), .pre_to_wdt(pre_to_wdt),
    .pre_sel(pre_sel), .wdt_tick(wdt_tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_wdt(clr_wdt), .pre_to_wdt(pre_to_wdt),
    .wdt_tick(wdt_tick), .ovf(ovf)
  );

  wdog_status u_stat (
    .clk(clk), .rst_n(rst_n), .clr_wdt(clr_wdt), .ovf(ovf),
    .rst_req(rst_req), .to_flag(to_flag), .pd_flag(pd_flag)
  );
endmodule

// File: tb/wdog_shared_pre_bench.sv
module wdog_shared_pre_bench;
  localparam int CW = 4;
  localparam int SW = 3;
  localparam int PW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_wdt = 1'b0;
  logic pre_to_wdt = 1'b1;
  logic [SW-1:0] pre_sel = '0;
  logic rst_req, to_flag, pd_flag;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  logic [CW-1:0] m_cnt;
  logic [PW-1:0] m_pre;
  logic m_to, m_pd, m_req;

  always #10 clk = ~clk;

  wdog_shared_pre #(.CNT_W(CW), .SEL_W(SW)) u_wdog_shared_pre (
    .clk(clk), .rst_n(rst_n), .clr_wdt(clr_wdt), .pre_to_wdt(pre_to_wdt),
    .pre_sel(pre_sel), .rst_req(rst_req), .to_flag(to_flag), .pd_flag(pd_flag)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired: act=%0d exp<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int period(input int s, input bit own);
    return own ? (1 << (CW + s)) : (1 << CW);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [PW-1:0] msk;
    logic tk, ov;
    msk = (PW'(1) << pre_sel) - PW'(1);
    tk = pre_to_wdt ? ((m_pre & msk) == msk) : 1'b1;
    if (clr_wdt) begin
      m_cnt = '0;
      if (pre_to_wdt) m_pre = '0;
      m_to = 1'b1; m_pd = 1'b1; m_req = 1'b0;
    end else begin
      ov = tk && (m_cnt == {CW{1'b1}});
      m_req = ov;
      if (tk) m_cnt = m_cnt + 1'b1;
      if (pre_to_wdt) m_pre = m_pre + 1'b1;
      if (ov) m_to = 1'b0;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R4 rst_req", int'(rst_req), int'(m_req));
    chk("R3 to_flag", int'(to_flag), int'(m_to));
    chk("R9 pd_flag", int'(pd_flag), int'(m_pd));
  endtask

  task automatic do_clear();
    clr_wdt = 1'b1;
    step();
    clr_wdt = 1'b0;
  endtask

  // edges after the clear edge until rst_req is seen
  task automatic run_to_req(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      step();
      n++;
      if (rst_req) break;
    end
  endtask

  initial begin
    int n;
    m_cnt = '0; m_pre = '0; m_to = 1'b1; m_pd = 1'b1; m_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset to_flag", int'(to_flag), 1);
    chk("R1 reset pd_flag", int'(pd_flag), 1);
    chk("R1 reset rst_req", int'(rst_req), 0);
    pre_to_wdt = 1'b1; pre_sel = 3'd1;
    rst_n = 1'b1;
    run_to_req(n);
    chk("R1 first period after reset", n, period(1, 1'b1));

    // R4: single-cycle pulse, to_flag sticky low
    step();
    chk("R4 pulse ends", int'(rst_req), 0);
    chk("R4 to_flag low", int'(to_flag), 0);
    repeat (5) step();
    chk("R4 to_flag stays low", int'(to_flag), 0);
    chk("R9 pd after overflow", int'(pd_flag), 1);

    // R3: clear sets flags
    do_clear();
    chk("R3 to set by clear", int'(to_flag), 1);
    chk("R3 pd set by clear", int'(pd_flag), 1);

    // R5: timer owns prescaler, select ignored
    pre_to_wdt = 1'b0; pre_sel = 3'd5;
    do_clear();
    run_to_req(n);
    chk("R5 period without prescaler", n, period(5, 1'b0));

    // R6: ratios
    pre_to_wdt = 1'b1;
    for (int s = 0; s < 8; s += 1) begin
      if (s == 0 || s == 2 || s == 7) begin
        pre_sel = SW'(s);
        do_clear();
        run_to_req(n);
        chk("R6 prescaled period", n, period(s, 1'b1));
      end
    end

    // R2: clear mid-period restarts
    pre_sel = 3'd2;
    do_clear();
    repeat (30) step();
    do_clear();
    run_to_req(n);
    chk("R2 restart after mid clear", n, period(2, 1'b1));

    // R7: prescaler kept through timer ownership and clear
    pre_sel = 3'd3;
    do_clear();
    repeat (3) step();
    pre_to_wdt = 1'b0;
    do_clear();
    pre_to_wdt = 1'b1;
    run_to_req(n);
    chk("R7 prescaler preserved", n, period(3, 1'b1) - 3);

    // R8: clear on the overflow edge
    pre_to_wdt = 1'b0;
    do_clear();
    repeat (15) step();
    do_clear();
    chk("R8 no request on clear edge", int'(rst_req), 0);
    chk("R8 to_flag kept", int'(to_flag), 1);
    run_to_req(n);
    chk("R8 period after colliding clear", n, period(0, 1'b0));

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      clr_wdt = ($urandom % 40) == 0;
      if (($urandom % 60) == 0) pre_to_wdt = ~pre_to_wdt;
      if (($urandom % 80) == 0) pre_sel = SW'($urandom % 4);
      step();
    end
    clr_wdt = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule